// File: doc/BRIEF.md
# Clock stop and power-down gate

This block sits between a set of free-running internal clock sources and the clock output ports of a system clock generator. It decides, per output, whether the source clock is passed through or parked, under three asynchronous active-low pins (power-down, PCI-class stop, CPU stop) and a set of quasi-static register bits (per-output enables, per-pair CPU free-run bits, per-output PCIF stop masks and a software PCI-stop bit). The register bits come from a register file elsewhere, which also owns their reset values.

The single-ended outputs (seven PCI, three PCIF, six 66 MHz-class, one reference and two 48 MHz outputs) are parked low. Each of the three differential CPU pairs is parked with its true side driven high and its complement side released, which is shown by a per-pair float flag for the analog driver to act on. Every control reaches each output through a two-flop synchronizer clocked by that output's own source, and the gate itself only changes while it cannot cut a pulse, so every stop and every restart is free of runt pulses.

Top module: `clk_stop_gate`

## Requirements
- R1: A control change reaches an output through two flops in the output's source domain: a single-ended output that is restarted while its source is low first goes high on the third source rising edge after the change, one that is stopped still passes the first two source pulses, and a CPU pair leaves or enters the parked state (float flag) at the third source rising edge.
- R2: While `pwrdn_n` is 0, every single-ended output is held at 0.
- R3: While `pwrdn_n` is 0, every CPU pair is parked: `cpu_t` = 1, `cpu_c` = 0 and `cpu_float` = 1; while a pair runs, `cpu_float` = 0 and `cpu_c` is the inverse of `cpu_t`.
- R4: The PCI stop is active when `pcistop_n` is 0 or `sw_pcistop_n` is 0; while it is active all `pci_out` bits are held at 0, and it has no effect on the 66 MHz, reference, 48 MHz or CPU outputs.
- R5: A PCIF output whose `pcif_stop_mask` bit is 1 is held at 0 while the PCI stop is active; with the bit at 0 it keeps running through a PCI stop.
- R6: While `cpustop_n` is 0, each CPU pair whose `cpu_free` bit is 0 is parked as in R3; a pair whose `cpu_free` bit is 1 keeps running.
- R7: `cpustop_n` has no effect on any single-ended output.
- R8: An output whose enable bit is 0 is stopped whatever the pins say: a single-ended output is held at 0, a CPU pair is parked as in R3.
- R9: A running output reproduces every source pulse; every high phase of a single-ended output and every low phase of `cpu_t` lasts a full source half period, including the first and last ones around a stop.
- R10: While `rst_n` is 0, all single-ended outputs are 0 and all CPU pairs are parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the gating state |
| cpu_src_clk | input | 1 | Source clock for the CPU pairs |
| m66_src_clk | input | 1 | Source clock for the 66 MHz-class outputs |
| pci_src_clk | input | 1 | Source clock for the PCI and PCIF outputs |
| ref_src_clk | input | 1 | Source clock for the reference output |
| f48_src_clk | input | 1 | Source clock for the 48 MHz outputs |
| pwrdn_n | input | 1 | Power-down pin, active low, asynchronous |
| pcistop_n | input | 1 | PCI stop pin, active low, asynchronous |
| cpustop_n | input | 1 | CPU stop pin, active low, asynchronous |
| sw_pcistop_n | input | 1 | Software PCI stop bit, active low |
| cpu_en | input | NCPU | Per-pair CPU enable |
| cpu_free | input | NCPU | Per-pair free-run bit, 1 = ignores CPU stop |
| pci_en | input | NPCI | Per-output PCI enable |
| pcif_en | input | NPCIF | Per-output PCIF enable |
| pcif_stop_mask | input | NPCIF | Per-output PCIF mask, 1 = stops with PCI stop |
| m66_en | input | N66 | Per-output 66 MHz enable |
| ref_en | input | 1 | Reference output enable |
| f48_en | input | N48 | Per-output 48 MHz enable |
| cpu_t | output | NCPU | CPU pair true side |
| cpu_c | output | NCPU | CPU pair complement side (0 while floated) |
| cpu_float | output | NCPU | 1 = complement side released to float |
| pci_out | output | NPCI | Gated PCI clocks |
| pcif_out | output | NPCIF | Gated PCIF clocks |
| m66_out | output | N66 | Gated 66 MHz-class clocks |
| ref_out | output | 1 | Gated reference clock |
| f48_out | output | N48 | Gated 48 MHz clocks |

## Verification
The bench sweeps all sixteen combinations of the four stop and power-down controls under three register patterns: everything enabled with default stop behaviour, every free-run and mask bit set, and a mixed pattern with some outputs disabled. Comparing edge counts of each output with its source over a settled window separates the pin-versus-register OR of the PCI stop, the per-output masks and free-run bits, and the priority of power-down and enables over everything else. Pulse-width tracking during the sweep tells whole pulses apart from cut ones, and single-edge restart and stop tests place a change just after a falling edge to pin down the two-flop latency.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int NCPU  = 3,
  parameter int NPCI  = 7,
  parameter int NPCIF = 3,
  parameter int N66   = 6,
  parameter int N48   = 2
) (
  input  logic             rst_n,
  input  logic             cpu_src_clk,
  input  logic             m66_src_clk,
  input  logic             pci_src_clk,
  input  logic             ref_src_clk,
  input  logic             f48_src_clk,
  input  logic             pwrdn_n,
  input  logic             pcistop_n,
  input  logic             cpustop_n,
  input  logic             sw_pcistop_n,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic [NCPU-1:0]  cpu_free,
  input  logic [NPCI-1:0]  pci_en,
  input  logic [NPCIF-1:0] pcif_en,
  input  logic [NPCIF-1:0] pcif_stop_mask,
  input  logic [N66-1:0]   m66_en,
  input  logic             ref_en,
  input  logic [N48-1:0]   f48_en,
  output logic [NCPU-1:0]  cpu_t,
  output logic [NCPU-1:0]  cpu_c,
  output logic [NCPU-1:0]  cpu_float,
  output logic [NPCI-1:0]  pci_out,
  output logic [NPCIF-1:0] pcif_out,
  output logic [N66-1:0]   m66_out,
  output logic             ref_out,
  output logic [N48-1:0]   f48_out
);

  localparam int O_PCIF = NPCI;
  localparam int O_66   = O_PCIF + NPCIF;
  localparam int O_REF  = O_66 + N66;
  localparam int O_48   = O_REF + 1;
  localparam int NLV    = O_48 + N48;

  logic            pci_halt;
  logic [NLV-1:0]  lv_run, lv_clk, lv_out;
  logic [NCPU-1:0] cpu_run;

  assign pci_halt = ~(pcistop_n & sw_pcistop_n);

  assign lv_run[O_PCIF-1:0]  = pci_en & {NPCI{pwrdn_n & ~pci_halt}};
  assign lv_run[O_66-1:O_PCIF] = pcif_en & ~(pcif_stop_mask & {NPCIF{pci_halt}})
                                 & {NPCIF{pwrdn_n}};
  assign lv_run[O_REF-1:O_66] = m66_en & {N66{pwrdn_n}};
  assign lv_run[O_REF]        = ref_en & pwrdn_n;
  assign lv_run[NLV-1:O_48]   = f48_en & {N48{pwrdn_n}};

  assign lv_clk = {{N48{f48_src_clk}}, ref_src_clk, {N66{m66_src_clk}},
                   {NPCIF{pci_src_clk}}, {NPCI{pci_src_clk}}};

  for (genvar i = 0; i < NLV; i++) begin : g_lv
    logic s1, s2, gate;
    always_ff @(posedge lv_clk[i] or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= lv_run[i];
        s2 <= s1;
      end
    always_ff @(negedge lv_clk[i] or negedge rst_n)
      if (!rst_n) gate <= 1'b0;
      else        gate <= s2;
    assign lv_out[i] = lv_clk[i] & gate;
  end

  assign pci_out  = lv_out[O_PCIF-1:0];
  assign pcif_out = lv_out[O_66-1:O_PCIF];
  assign m66_out  = lv_out[O_REF-1:O_66];
  assign ref_out  = lv_out[O_REF];
  assign f48_out  = lv_out[NLV-1:O_48];

  assign cpu_run = cpu_en & (cpu_free | {NCPU{cpustop_n}}) & {NCPU{pwrdn_n}};

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic c1, c2, park;
    always_ff @(posedge cpu_src_clk or negedge rst_n)
      if (!rst_n) begin
        c1   <= 1'b0;
        c2   <= 1'b0;
        park <= 1'b1;
      end else begin
        c1   <= cpu_run[i];
        c2   <= c1;
        park <= ~c2;
      end
    assign cpu_t[i]     = cpu_src_clk | park;
    assign cpu_c[i]     = ~cpu_src_clk & ~park;
    assign cpu_float[i] = park;
  end

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int NCPU  = 3,
  parameter int NPCI  = 7,
  parameter int NPCIF = 3,
  parameter int NLV   = 19
) (
  input logic             rst_n,
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             ref_clk,
  input logic             pwrdn_n,
  input logic             pcistop_n,
  input logic             sw_pcistop_n,
  input logic             cpustop_n,
  input logic [NCPU-1:0]  cpu_free,
  input logic [NPCIF-1:0] pcif_en,
  input logic [NPCIF-1:0] pcif_stop_mask,
  input logic [NCPU-1:0]  cpu_float,
  input logic [NPCI-1:0]  pci_out,
  input logic [NPCIF-1:0] pcif_out,
  input logic             ref_out,
  input logic [NLV-1:0]   lv_o,
  input logic [NLV-1:0]   lv_c
);

  // R2
  pd_low_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
    |-> !ref_out);

  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    // R4
    pci_halt_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
      (!(pcistop_n && sw_pcistop_n) && !$past(pcistop_n && sw_pcistop_n)
       && !$past(pcistop_n && sw_pcistop_n, 2) && !$past(pcistop_n && sw_pcistop_n, 3))
      |-> !pci_out[i]);
  end

  for (genvar j = 0; j < NPCIF; j++) begin : g_pcif
    // R5
    pcif_free_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
      ((rst_n && pwrdn_n && pcif_en[j] && !pcif_stop_mask[j])
       && $past(rst_n && pwrdn_n && pcif_en[j] && !pcif_stop_mask[j])
       && $past(rst_n && pwrdn_n && pcif_en[j] && !pcif_stop_mask[j], 2)
       && $past(rst_n && pwrdn_n && pcif_en[j] && !pcif_stop_mask[j], 3))
      |-> pcif_out[j]);
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    // R6
    cpu_park_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      ((!cpustop_n && !cpu_free[i]) && $past(!cpustop_n && !cpu_free[i])
       && $past(!cpustop_n && !cpu_free[i], 2) && $past(!cpustop_n && !cpu_free[i], 3))
      |-> cpu_float[i]);
  end

  for (genvar i = 0; i < NLV; i++) begin : g_lv
    always @(negedge lv_o[i])
      if (rst_n)
        // R9
        glitch_chk: assert (!lv_c[i]);
  end

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .NCPU(NCPU), .NPCI(NPCI), .NPCIF(NPCIF), .NLV(NLV)
) u_chk (
  .rst_n(rst_n), .cpu_clk(cpu_src_clk), .pci_clk(pci_src_clk), .ref_clk(ref_src_clk),
  .pwrdn_n(pwrdn_n), .pcistop_n(pcistop_n), .sw_pcistop_n(sw_pcistop_n),
  .cpustop_n(cpustop_n), .cpu_free(cpu_free), .pcif_en(pcif_en),
  .pcif_stop_mask(pcif_stop_mask), .cpu_float(cpu_float), .pci_out(pci_out),
  .pcif_out(pcif_out), .ref_out(ref_out), .lv_o(lv_out), .lv_c(lv_clk)
);

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;

  logic bclk = 0, cpu_clk = 0, m66_clk = 0, pci_clk = 0, ref_clk = 0, f48_clk = 0;
  always #5  bclk    = ~bclk;
  always #3  cpu_clk = ~cpu_clk;
  always #7  m66_clk = ~m66_clk;
  always #14 pci_clk = ~pci_clk;
  always #35 ref_clk = ~ref_clk;
  always #10 f48_clk = ~f48_clk;

  logic rst_n, pwrdn_n, pcistop_n, cpustop_n, sw_pcistop_n;
  logic [2:0] cpu_en, cpu_free, pcif_en, pcif_mask;
  logic [6:0] pci_en;
  logic [5:0] m66_en;
  logic       ref_en;
  logic [1:0] f48_en;
  logic [2:0] cpu_t, cpu_c, cpu_float, pcif_out;
  logic [6:0] pci_out;
  logic [5:0] m66_out;
  logic       ref_out;
  logic [1:0] f48_out;

  clk_stop_gate dut (
    .rst_n(rst_n), .cpu_src_clk(cpu_clk), .m66_src_clk(m66_clk), .pci_src_clk(pci_clk),
    .ref_src_clk(ref_clk), .f48_src_clk(f48_clk), .pwrdn_n(pwrdn_n), .pcistop_n(pcistop_n),
    .cpustop_n(cpustop_n), .sw_pcistop_n(sw_pcistop_n), .cpu_en(cpu_en), .cpu_free(cpu_free),
    .pci_en(pci_en), .pcif_en(pcif_en), .pcif_stop_mask(pcif_mask), .m66_en(m66_en),
    .ref_en(ref_en), .f48_en(f48_en), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_float(cpu_float),
    .pci_out(pci_out), .pcif_out(pcif_out), .m66_out(m66_out), .ref_out(ref_out),
    .f48_out(f48_out)
  );

  wire [18:0] lv    = {f48_out, ref_out, m66_out, pcif_out, pci_out};
  wire [18:0] lv_en = {f48_en, ref_en, m66_en, pcif_en, pci_en};
  wire [4:0]  srcv  = {f48_clk, ref_clk, pci_clk, m66_clk, cpu_clk};

  int checks = 0, errors = 0;
  int ocnt[19], ccnt[3], scnt[5];
  bit lv_up[19], cpu_dn[3], lv_ran[19], cpu_ran[3];
  real lv_rise[19], cpu_fall[3], lv_minh[19], cpu_minl[3];
  int cmis;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int grp_of(input int i);
    if (i < 10) return 2;
    if (i < 16) return 1;
    if (i == 16) return 3;
    return 4;
  endfunction

  function automatic int half_of(input int g);
    case (g)
      0: return 3;
      1: return 7;
      2: return 14;
      3: return 35;
      default: return 10;
    endcase
  endfunction

  function automatic bit exp_lv(input int i);
    bit halt = !(pcistop_n && sw_pcistop_n);
    bit r = pwrdn_n && lv_en[i];
    if (i < 7) r = r && !halt;
    else if (i < 10) r = r && !(halt && pcif_mask[i-7]);
    return r;
  endfunction

  function automatic bit exp_cpu(input int i);
    return pwrdn_n && cpu_en[i] && (cpustop_n || cpu_free[i]);
  endfunction

  function automatic string tag_lv(input int i);
    if (!pwrdn_n) return "R2";
    if (!lv_en[i]) return "R8";
    if (i < 7) return "R4";
    if (i < 10) return "R5";
    if (!cpustop_n) return "R7";
    return "R9";
  endfunction

  function automatic string tag_cpu(input int i);
    if (!pwrdn_n) return "R3";
    if (!cpu_en[i]) return "R8";
    if (!cpustop_n) return "R6";
    return "R9";
  endfunction

  task automatic set_pattern(input int p);
    case (p)
      0: begin
        cpu_en = '1; cpu_free = '0; pci_en = '1; pcif_en = '1; pcif_mask = '0;
        m66_en = '1; ref_en = 1; f48_en = '1;
      end
      1: begin
        cpu_en = '1; cpu_free = '1; pci_en = '1; pcif_en = '1; pcif_mask = '1;
        m66_en = '1; ref_en = 1; f48_en = '1;
      end
      default: begin
        cpu_en = 3'b101; cpu_free = 3'b010; pci_en = 7'b1010101; pcif_en = 3'b110;
        pcif_mask = 3'b101; m66_en = 6'b110011; ref_en = 0; f48_en = 2'b10;
      end
    endcase
  endtask

  task automatic measure(input int n);
    logic [18:0] plv = lv;
    logic [2:0]  pct = cpu_t;
    logic [4:0]  psr = srcv;
    for (int i = 0; i < 19; i++) begin ocnt[i] = 0; lv_up[i] = 0; end
    for (int i = 0; i < 3; i++) begin ccnt[i] = 0; cpu_dn[i] = 0; end
    for (int i = 0; i < 5; i++) scnt[i] = 0;
    cmis = 0;
    repeat (n) begin
      #0.5;
      for (int i = 0; i < 5; i++) if (srcv[i] && !psr[i]) scnt[i]++;
      for (int i = 0; i < 19; i++) begin
        if (lv[i] && !plv[i]) begin ocnt[i]++; lv_up[i] = 1; lv_rise[i] = $realtime; end
        if (!lv[i] && plv[i] && lv_up[i]) begin
          lv_ran[i] = 1;
          if ($realtime - lv_rise[i] < lv_minh[i]) lv_minh[i] = $realtime - lv_rise[i];
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (cpu_t[i] && !pct[i]) begin
          ccnt[i]++;
          if (cpu_dn[i]) begin
            cpu_ran[i] = 1;
            if ($realtime - cpu_fall[i] < cpu_minl[i]) cpu_minl[i] = $realtime - cpu_fall[i];
          end
        end
        if (!cpu_t[i] && pct[i]) begin cpu_dn[i] = 1; cpu_fall[i] = $realtime; end
        if (cpu_float[i] ? (cpu_c[i] !== 1'b0) : (cpu_c[i] !== ~cpu_t[i])) cmis++;
      end
      plv = lv; pct = cpu_t; psr = srcv;
    end
  endtask

  task automatic judge();
    for (int i = 0; i < 19; i++) begin
      int s = scnt[grp_of(i)];
      if (exp_lv(i)) chk(ocnt[i] == s, tag_lv(i), $sformatf("lv%0d edges", i), ocnt[i], s);
      else chk(ocnt[i] == 0 && lv[i] == 0, tag_lv(i), $sformatf("lv%0d held low", i),
               ocnt[i] + int'(lv[i]), 0);
    end
    for (int i = 0; i < 3; i++) begin
      if (exp_cpu(i))
        chk(ccnt[i] == scnt[0] && !cpu_float[i], tag_cpu(i), $sformatf("cpu%0d run", i),
            ccnt[i], scnt[0]);
      else
        chk(ccnt[i] == 0 && cpu_t[i] && !cpu_c[i] && cpu_float[i], tag_cpu(i),
            $sformatf("cpu%0d parked t/c/f", i),
            {cpu_t[i], cpu_c[i], cpu_float[i]}, 3'b101);
    end
    chk(cmis == 0, "R3", "complement shape samples", cmis, 0);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first, highs;
    for (int i = 0; i < 19; i++) begin lv_minh[i] = 1.0e9; lv_ran[i] = 0; end
    for (int i = 0; i < 3; i++) begin cpu_minl[i] = 1.0e9; cpu_ran[i] = 0; end
    rst_n = 0; pwrdn_n = 1; pcistop_n = 1; cpustop_n = 1; sw_pcistop_n = 1;
    set_pattern(0);
    #50.25;
    // R10 reset state
    chk(lv == '0, "R10", "single-ended outputs in reset", int'(lv), 0);
    chk(cpu_t == 3'b111 && cpu_c == 3'b000 && cpu_float == 3'b111, "R10",
        "cpu pairs parked in reset", {cpu_t, cpu_c, cpu_float}, 9'b111000111);
    #50 rst_n = 1;

    for (int p = 0; p < 3; p++) begin
      set_pattern(p);
      for (int c = 0; c < 16; c++) begin
        pwrdn_n = c[3]; pcistop_n = c[2]; sw_pcistop_n = c[1]; cpustop_n = c[0];
        #400;
        measure(1960);
        judge();
      end
    end

    for (int i = 0; i < 19; i++)
      if (lv_ran[i])
        chk(lv_minh[i] == real'(half_of(grp_of(i))), "R9",
            $sformatf("lv%0d min high width ns", i), int'(lv_minh[i]), half_of(grp_of(i)));
    for (int i = 0; i < 3; i++)
      if (cpu_ran[i])
        chk(cpu_minl[i] == 3.0, "R9", $sformatf("cpu%0d min low width ns", i),
            int'(cpu_minl[i]), 3);

    // R1 latency on restart and stop
    set_pattern(0);
    pwrdn_n = 0; pcistop_n = 1; sw_pcistop_n = 1; cpustop_n = 1;
    #400;
    @(negedge pci_clk); #1 pwrdn_n = 1;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge pci_clk); #1;
      if (pci_out[0] && first == 0) first = k;
    end
    chk(first == 3, "R1", "restart first pulse edge", first, 3);
    @(negedge pci_clk); #1 pwrdn_n = 0;
    highs = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge pci_clk); #1;
      if (pci_out[0]) highs++;
    end
    chk(highs == 2, "R1", "pulses passed after stop", highs, 2);
    #400;
    @(negedge cpu_clk); #0.5 pwrdn_n = 1;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge cpu_clk); #1;
      if (!cpu_float[0] && first == 0) first = k;
    end
    chk(first == 3, "R1", "cpu release edge", first, 3);
    @(negedge cpu_clk); #0.5 pwrdn_n = 0;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge cpu_clk); #1;
      if (cpu_float[0] && first == 0) first = k;
    end
    chk(first == 3, "R1", "cpu park edge", first, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule